// File: doc/BRIEF.md
# Multiplexed Segment LCD Frame Sequencer

This block paces the drive of a multiplexed segment LCD. On every cycle where the LCD clock enable is high, it moves a position counter through the time slot of the active common. It steps the common index when a slot ends and raises a one-cycle strobe on the last enabled clock of each frame. The length of a slot depends on the multiplex mode and on a 4-bit prescaler. The mode gives each common slot K equal sub-slots (K = 4 static, 2 half, 1 third, 1 quarter), and each sub-slot lasts prescaler + 1 enabled clocks.

Every COM and SEG line is given an abstract drive-level code. Two waveform families control when the drive phase inverts. The first inverts in the middle of each common slot. The second holds one phase for a whole frame and inverts at each frame boundary, so two frames make one DC-balanced pair. Prescaler, mode and waveform changes take effect only at a frame boundary.

A sleep request is granted only where every pixel carries zero net DC. While asleep, all lines sit at the mid level and the counters hold until the request drops.

Top module: `lcd_frame_seq`

## Requirements
- R1: During and right after synchronous reset (`rst_n` low), `com_sel` is 0, `drive_phase` is 0, `sleep_ok` is 0 and the sequencer stands at the first clock of a frame. The configuration inputs present during reset are taken as the first frame's settings.
- R2: A frame lasts K·N·(P+1) enabled clocks, where P is `prescale` and N = `mux_mode`+1. `mux_mode` is encoded 0 = static (K=4, N=1), 1 = half (K=2, N=2), 2 = third (K=1, N=3), 3 = quarter (K=1, N=4).
- R3: `com_sel` holds for L = K·(P+1) enabled clocks, then steps by one and wraps from N−1 to 0.
- R4: With `wave_b` = 0, `drive_phase` is 0 at slot positions q where 2q < L, and 1 otherwise.
- R5: With `wave_b` = 1, `drive_phase` is constant over a frame, starts at 0 after reset, and inverts at every frame boundary.
- R6: Each COM has a 2-bit code at bits [2c+1:2c] of `com_lvl`, with levels low = 0, mid = 1 and high = 3. The common selected by `com_sel` gets high when the phase is 0 and low when it is 1. Every other common gets mid.
- R7: Segment s of common c is read from `seg_data` bit c·NSEG+s, where 1 means dark. Its code at `seg_lvl` bits [2s+1:2s] is the opposite extreme of the active COM when the pixel is dark, and the same extreme when it is clear.
- R8: Changes to `prescale`, `mux_mode` or `wave_b` in the middle of a frame do not change that frame's length. They apply from the next frame.
- R9: `frame_strobe` is high exactly on the last enabled clock of each frame, and at no other time.
- R10: `sleep_ok` rises only in the cycle after a frame end where the drive is DC balanced and `sleep_req` is high. With `wave_b` = 0, any frame end is balanced. With `wave_b` = 1, only the end of a frame run at phase 1 is balanced.
- R11: While `sleep_ok` is high, all COM and SEG codes are mid (1), `frame_strobe` stays low and `com_sel` stays 0. One cycle after `sleep_req` drops, `sleep_ok` is 0 and a new frame starts at common 0, phase 0, with the inputs present at wake-up as its settings.
- R12: When `lcd_ce` is low, `com_sel`, `drive_phase` and the frame position hold, and `frame_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lcd_ce | input | 1 | LCD clock enable; one count per high cycle |
| prescale | input | 4 | Sub-slot length minus one |
| mux_mode | input | 2 | 0 static, 1 half, 2 third, 3 quarter |
| wave_b | input | 1 | 0 = invert inside each slot, 1 = invert per frame |
| seg_data | input | 4·NSEG | Pixel bits, common-major |
| sleep_req | input | 1 | Request to stop at the next balanced point |
| com_sel | output | 2 | Active common index |
| drive_phase | output | 1 | Current drive polarity |
| com_lvl | output | 8 | Level code per COM line |
| seg_lvl | output | 2·NSEG | Level code per SEG line |
| frame_strobe | output | 1 | Last enabled clock of a frame |
| sleep_ok | output | 1 | Asleep at a zero-DC point |

## Verification
A slot-position counter with the wrong value shows up at once as a phase edge that is off by one clock, and within one slot as a common step that comes early or late. A wrong latched setting changes the frame length, and the frame strobe shows this by the end of that frame. A wrong phase-pair flag in the per-frame waveform does not show until a sleep request: `sleep_ok` then rises one frame too early or too late. The bench therefore requests sleep in both frames of a pair.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int PS_W   = 4;
  localparam int NCOM   = 4;
  localparam int SLOT_W = PS_W + 3;

  typedef enum logic [1:0] {
    MUX_STATIC = 2'd0,
    MUX_HALF   = 2'd1,
    MUX_THIRD  = 2'd2,
    MUX_QUART  = 2'd3
  } mux_e;

  typedef enum logic [1:0] {
    LV_LOW  = 2'd0,
    LV_MID  = 2'd1,
    LV_HIGH = 2'd3
  } lvl_e;

  // sub-slots per common slot for each mode
  function automatic logic [2:0] sub_per_slot(mux_e m);
    case (m)
      MUX_STATIC: return 3'd4;
      MUX_HALF:   return 3'd2;
      default:    return 3'd1;
    endcase
  endfunction

  // number of commons scanned in a frame
  function automatic logic [2:0] com_count(mux_e m);
    return {1'b0, m} + 3'd1;
  endfunction

  // enabled clocks in one common slot
  function automatic logic [SLOT_W-1:0] slot_len(mux_e m, logic [PS_W-1:0] ps);
    logic [SLOT_W-1:0] unit;
    unit = SLOT_W'(ps) + SLOT_W'(1);
    return SLOT_W'(unit * SLOT_W'(sub_per_slot(m)));
  endfunction
endpackage

// File: rtl/lcd_seq_timer.sv
module lcd_seq_timer
  import lcd_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lcd_ce,
  input  logic [PS_W-1:0] ps_in,
  input  logic [1:0]      mode_in,
  input  logic            wave_in,
  input  logic            sleep_req,
  output logic [1:0]      com_o,
  output logic            phase_o,
  output logic            frame_end_o,
  output logic            sleep_o
);
  mux_e              cfg_mode;
  logic [PS_W-1:0]   cfg_ps;
  logic              cfg_b;
  logic [SLOT_W-1:0] pos;
  logic [SLOT_W-1:0] len;
  logic [1:0]        com_q;
  logic              par_q;
  logic              sleep_q;

  // named internal events
  logic last_pos, last_com, fe, balanced, phase_a;

  assign len      = slot_len(cfg_mode, cfg_ps);
  assign last_pos = (pos == len - SLOT_W'(1));
  assign last_com = ({1'b0, com_q} == com_count(cfg_mode) - 3'd1);
  assign fe       = lcd_ce & ~sleep_q & last_pos & last_com;
  assign balanced = ~cfg_b | par_q;
  assign phase_a  = ({pos, 1'b0} >= {1'b0, len});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos      <= '0;
      com_q    <= '0;
      par_q    <= 1'b0;
      sleep_q  <= 1'b0;
      cfg_mode <= mux_e'(mode_in);
      cfg_ps   <= ps_in;
      cfg_b    <= wave_in;
    end else if (sleep_q) begin
      if (!sleep_req) begin
        sleep_q  <= 1'b0;
        cfg_mode <= mux_e'(mode_in);
        cfg_ps   <= ps_in;
        cfg_b    <= wave_in;
      end
    end else if (lcd_ce) begin
      if (!last_pos) begin
        pos <= pos + SLOT_W'(1);
      end else begin
        pos <= '0;
        if (!last_com) begin
          com_q <= com_q + 2'd1;
        end else begin
          com_q    <= '0;
          cfg_mode <= mux_e'(mode_in);
          cfg_ps   <= ps_in;
          cfg_b    <= wave_in;
          if (sleep_req && balanced) begin
            sleep_q <= 1'b1;
            par_q   <= 1'b0;
          end else begin
            par_q <= (cfg_b & wave_in) ? ~par_q : 1'b0;
          end
        end
      end
    end
  end

  assign com_o       = com_q;
  assign phase_o     = cfg_b ? par_q : phase_a;
  assign frame_end_o = fe;
  assign sleep_o     = sleep_q;

  a_r10_sleep_on_balance: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_q) |-> $past(fe && balanced && sleep_req));

  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(fe) && !$past(sleep_q))
      |-> ($stable(cfg_ps) && $stable(cfg_mode) && $stable(cfg_b)));

  a_r3_com_range: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, com_q} < com_count(cfg_mode)));

  a_r5_frame_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe && cfg_b && !sleep_q) |=> $stable(par_q));

  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_ce && !sleep_q) |=> ($stable(pos) && $stable(com_q)));

  a_r9_wrap_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    fe |=> (pos == '0 && com_q == 2'd0));
endmodule

// File: rtl/lcd_seq_drive.sv
module lcd_seq_drive
  import lcd_seq_pkg::*;
#(
  parameter int NSEG = 8
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           com_i,
  input  logic                 phase_i,
  input  logic                 sleep_i,
  input  logic [NCOM*NSEG-1:0] seg_data,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl
);
  localparam int ROW_W = NSEG;

  logic [1:0]       on_lvl, off_lvl;
  logic [ROW_W-1:0] row;
  logic [NCOM-1:0]  com_hot;
  logic [NSEG-1:0]  seg_mid;

  assign on_lvl  = phase_i ? LV_LOW  : LV_HIGH;
  assign off_lvl = phase_i ? LV_HIGH : LV_LOW;
  assign row     = seg_data[com_i*NSEG +: NSEG];

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_lvl[2*c +: 2] = sleep_i ? LV_MID :
                               (com_i == 2'(c)) ? on_lvl : LV_MID;
    assign com_hot[c] = (com_lvl[2*c +: 2] != LV_MID);
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_lvl[2*s +: 2] = sleep_i ? LV_MID : (row[s] ? off_lvl : on_lvl);
    assign seg_mid[s] = (seg_lvl[2*s +: 2] == LV_MID);
  end

  a_r6_one_active_com: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> ($countones(com_hot) == 1));

  a_r11_all_mid_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (com_hot == '0 && (&seg_mid)));

  a_r7_seg_extreme: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_i |-> (seg_mid == '0));
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
  import lcd_seq_pkg::*;
#(
  parameter int NSEG = 8
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lcd_ce,
  input  logic [PS_W-1:0]      prescale,
  input  logic [1:0]           mux_mode,
  input  logic                 wave_b,
  input  logic [NCOM*NSEG-1:0] seg_data,
  input  logic                 sleep_req,
  output logic [1:0]           com_sel,
  output logic                 drive_phase,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NSEG-1:0]    seg_lvl,
  output logic                 frame_strobe,
  output logic                 sleep_ok
);
  logic [1:0] com_w;
  logic       phase_w, fe_w, sleep_w;

  lcd_seq_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .lcd_ce      (lcd_ce),
    .ps_in       (prescale),
    .mode_in     (mux_mode),
    .wave_in     (wave_b),
    .sleep_req   (sleep_req),
    .com_o       (com_w),
    .phase_o     (phase_w),
    .frame_end_o (fe_w),
    .sleep_o     (sleep_w)
  );

  lcd_seq_drive #(.NSEG(NSEG)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .com_i    (com_w),
    .phase_i  (phase_w),
    .sleep_i  (sleep_w),
    .seg_data (seg_data),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );

  assign com_sel      = com_w;
  assign drive_phase  = phase_w;
  assign frame_strobe = fe_w;
  assign sleep_ok     = sleep_w;

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (com_sel == 2'd0 && !drive_phase && !sleep_ok));

  a_r11_no_strobe_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ok |-> (!frame_strobe && com_sel == 2'd0));
endmodule

// File: tb/lcd_frame_seq_tb.sv
module lcd_frame_seq_tb;
  localparam int NSEG = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lcd_ce = 1'b1;
  logic [3:0]       prescale = '0;
  logic [1:0]       mux_mode = '0;
  logic             wave_b = 1'b0;
  logic [4*NSEG-1:0] seg_data = 32'h96F0_A5C3;
  logic             sleep_req = 1'b0;
  logic [1:0]       com_sel;
  logic             drive_phase;
  logic [7:0]       com_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic             frame_strobe;
  logic             sleep_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_frame_seq #(.NSEG(NSEG)) u_dut (
    .clk(clk), .rst_n(rst_n), .lcd_ce(lcd_ce), .prescale(prescale),
    .mux_mode(mux_mode), .wave_b(wave_b), .seg_data(seg_data),
    .sleep_req(sleep_req), .com_sel(com_sel), .drive_phase(drive_phase),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl), .frame_strobe(frame_strobe),
    .sleep_ok(sleep_ok)
  );

  // {wave, mode[1:0], prescale[3:0]}
  localparam logic [6:0] VEC [8] = '{
    {1'b0, 2'd0, 4'd0},  {1'b0, 2'd1, 4'd2},  {1'b0, 2'd2, 4'd3},
    {1'b0, 2'd3, 4'd1},  {1'b1, 2'd2, 4'd4},  {1'b1, 2'd0, 4'd15},
    {1'b0, 2'd3, 4'd15}, {1'b1, 2'd1, 4'd0}
  };

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int k_of(int m);
    return (m == 0) ? 4 : (m == 1) ? 2 : 1;
  endfunction

  function automatic logic [7:0] exp_com(int ecom, bit eph);
    logic [7:0] v;
    for (int c = 0; c < 4; c++) v[2*c +: 2] = (c == ecom) ? (eph ? 2'd0 : 2'd3) : 2'd1;
    return v;
  endfunction

  function automatic logic [2*NSEG-1:0] exp_seg(int ecom, bit eph);
    logic [2*NSEG-1:0] v;
    logic [1:0] same, opp;
    same = eph ? 2'd0 : 2'd3;
    opp  = eph ? 2'd3 : 2'd0;
    for (int s = 0; s < NSEG; s++) v[2*s +: 2] = seg_data[ecom*NSEG + s] ? opp : same;
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // walks one full frame from position 0, checking every clock
  task automatic run_frame(int m, int ps, bit wb, bit par);
    int L, F, ecom, q;
    bit eph;
    L = k_of(m) * (ps + 1);
    F = L * (m + 1);
    for (int p = 0; p < F; p++) begin
      ecom = p / L;
      q    = p % L;
      eph  = wb ? par : (2 * q >= L);
      chk(com_sel == 2'(ecom), "R3 com_sel", com_sel, ecom);
      chk(drive_phase == eph, wb ? "R5 phase" : "R4 phase", drive_phase, eph);
      chk(frame_strobe == (p == F - 1), "R9/R2 strobe", frame_strobe, p == F - 1);
      chk(com_lvl == exp_com(ecom, eph), "R6 com_lvl", com_lvl, exp_com(ecom, eph));
      chk(seg_lvl == exp_seg(ecom, eph), "R7 seg_lvl", seg_lvl, exp_seg(ecom, eph));
      @(negedge clk);
    end
  endtask

  task automatic measure(output int n);
    n = 1;
    while (!frame_strobe && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    logic [1:0] c0;
    bit ph0;

    // R1: reset state
    do_reset();
    chk(com_sel == 2'd0 && !drive_phase, "R1 reset com/phase", {com_sel, drive_phase}, 0);
    chk(!sleep_ok && !frame_strobe, "R1 reset sleep/strobe", {sleep_ok, frame_strobe}, 0);

    // table walk: two frames per vector
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wave_b = VEC[i][6]; mux_mode = VEC[i][5:4]; prescale = VEC[i][3:0];
      do_reset();
      run_frame(int'(VEC[i][5:4]), int'(VEC[i][3:0]), VEC[i][6], 1'b0);
      run_frame(int'(VEC[i][5:4]), int'(VEC[i][3:0]), VEC[i][6], 1'b1);
    end

    // R8: mid-frame prescaler change applies at next frame
    wave_b = 1'b0; mux_mode = 2'd3; prescale = 4'd1;
    do_reset();
    prescale = 4'd3;
    measure(n);
    chk(n == 8, "R8 old frame length", n, 8);
    @(negedge clk);
    measure(n);
    chk(n == 16, "R8 new frame length", n, 16);

    // R12: enable low holds state
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);
    lcd_ce = 1'b0;
    c0 = com_sel; ph0 = drive_phase;
    for (int j = 0; j < 5; j++) @(negedge clk);
    chk(com_sel == c0 && drive_phase == ph0, "R12 hold", {com_sel, drive_phase}, {c0, ph0});
    chk(!frame_strobe, "R12 no strobe", frame_strobe, 0);
    lcd_ce = 1'b1;

    // R10/R11: slot-inverting waveform sleeps at any frame end
    mux_mode = 2'd1; prescale = 4'd1; wave_b = 1'b0;
    do_reset();
    sleep_req = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!sleep_ok, "R10 not mid-frame", sleep_ok, 0);
    measure(n);
    chk(!sleep_ok, "R10 not at strobe", sleep_ok, 0);
    @(negedge clk);
    chk(sleep_ok, "R10 asleep after A frame", sleep_ok, 1);
    chk(com_lvl == 8'h55 && seg_lvl == 16'h5555, "R11 mid levels", com_lvl, 8'h55);
    for (int j = 0; j < 5; j++) @(negedge clk);
    chk(sleep_ok && !frame_strobe && com_sel == 2'd0, "R11 held", {sleep_ok, frame_strobe, com_sel}, 4'b1000);
    sleep_req = 1'b0; mux_mode = 2'd3; prescale = 4'd0;
    @(negedge clk);
    chk(!sleep_ok && com_sel == 2'd0 && !drive_phase, "R11 wake", {sleep_ok, com_sel, drive_phase}, 0);
    measure(n);
    chk(n == 4, "R11 wake settings", n, 4);

    // R10: per-frame waveform needs the phase-1 frame
    @(negedge clk);
    mux_mode = 2'd2; prescale = 4'd0; wave_b = 1'b1;
    do_reset();
    sleep_req = 1'b1;
    measure(n);
    chk(n == 3, "R2 third ps0", n, 3);
    @(negedge clk);
    chk(!sleep_ok, "R10 B first frame", sleep_ok, 0);
    chk(drive_phase, "R5 B second frame phase", drive_phase, 1);
    measure(n);
    @(negedge clk);
    chk(sleep_ok, "R10 B after pair", sleep_ok, 1);
    sleep_req = 1'b0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule